// File: doc/BRIEF.md
# Memory-Mapped GPIO Port

A parameterized general-purpose I/O port controlled through a small synchronous register port. Software-side logic writes an output latch, a direction register and, in the set/clear style, separate write-one-to-set and write-one-to-clear strobes. It reads back either the synchronized pin levels or the output latch. On the pin side every pin has an input level, an output value and an output enable, which a pad ring turns into a tri-state driver.

Every variant is chosen at build time: the register width (8, 16, 32 or 64 bits), the pin count, the output-update style, the direction polarity, the bit numbering order, the byte order of register accesses, an input-only variant and three readback options. The register port is a plain single-cycle access with no back-pressure. A write is taken on the clock edge where `reg_wr` is high. A read is requested by `reg_rd`, and its data appears on `reg_rdata` one clock later and stays there until the next read. No valid/ready handshake is used, because no access ever stalls.

Top module: `gpio_port`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero and `reg_rdata` is zero.
- R2: Register addresses are data = 0, set = 1, clear = 2 and direction = 3. In single-data mode (`SET_CLR` = 0) a data write drives each pin to its written bit, so 1 gives high and 0 gives low. A data read returns the pin levels seen through a two-flop synchronizer: a pin change is not visible to a read issued one clock after it, but is visible to later reads.
- R3: In set/clear mode (`SET_CLR` = 1), a 1 written to the set address drives that pin high, a 1 written to the clear address drives it low, and 0 bits leave their pins unchanged. Writes to the data address are ignored. A readable set address returns the output latch, and the clear address reads zero.
- R4: With `DIR_OUT_POL` = 1 a direction bit of 1 makes its pin an output (`pin_oe` = 1). With `DIR_OUT_POL` = 0 a bit of 1 makes it an input. The reset value of the direction register leaves every pin an input.
- R5: With `MSB_FIRST` = 1, pin k corresponds to register bit REG_W-1-k rather than bit k.
- R6: With `BIG_ENDIAN` = 1, register data is byte-swapped on both writes and reads. For example, with 32 bits, MSB-first numbering and byte swap, bus bit 7 is pin 0 and bus bit 31 is pin 24.
- R7: With `INPUT_ONLY` = 1, writes to data, set, clear and direction are ignored, and `pin_oe` and `pin_out` stay zero.
- R8: With `SET_UNREADABLE` = 1, reads of the set address return zero.
- R9: With `OUT_READBACK` = 1, data reads return the output latch instead of the pin levels.
- R10: With `DIR_UNREADABLE` = 1, direction reads return zero, while the written value still controls `pin_oe`.
- R11: Read data is valid one clock after `reg_rd`. Reads of unmapped addresses (4 to 7, and 1 and 2 in single-data mode) return zero, and writes to them change nothing.
- R12: When `PIN_N` < `REG_W`, register bits at and above `PIN_N` read as zero and writing them affects no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, taken on the clock edge |
| reg_wdata | input | REG_W | Write data |
| reg_rd | input | 1 | Read request |
| reg_rdata | output | REG_W | Read data, valid the clock after `reg_rd` |
| pin_in | input | PIN_N | Pin input levels (asynchronous) |
| pin_out | output | PIN_N | Pin output values |
| pin_oe | output | PIN_N | Pin output enables, 1 = drive |

## Verification
The bench builds three instances side by side.

- The first uses 16-bit registers with 12 pins, set/clear style and output polarity. It exercises R3 and R12: partial set and clear masks, ignored data writes, and bits above the pin count.
- The second uses 32 bits in single-data style with input polarity, MSB-first numbering, byte swap, latch readback and a hidden direction register. Hand-computed single-bit writes pin down the combined bit and byte permutation.
- The third is an 8-bit input-only build with an unreadable set register. It shows that every write is dropped while pin levels still reach data reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 3'd3;

  // An address is mapped when it names a register present in this build.
  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a, input bit set_clr);
    logic m;
    m = (a == ADR_DATA) || (a == ADR_DIR);
    if (set_clr && ((a == ADR_SET) || (a == ADR_CLR))) m = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/gpio_lane_map.sv
// Permutes a register word between bus order and pin order. Bit reversal
// and byte swap are commuting involutions, so one instance serves both
// directions.
module gpio_lane_map #(
  parameter int W          = 32,
  parameter bit MSB_FIRST  = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [W-1:0] in_w,
  output logic [W-1:0] out_w
);
  localparam int NBYTES = W / 8;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int R = MSB_FIRST ? (W - 1 - i) : i;
    localparam int P = BIG_ENDIAN ? (8 * (NBYTES - 1 - R / 8) + R % 8) : R;
    assign out_w[i] = in_w[P];
  end
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for the asynchronous pin levels.
module gpio_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
// Output latch and direction register, both held in pin order.
module gpio_regs #(
  parameter int N           = 32,
  parameter bit SET_CLR     = 1'b0,
  parameter bit DIR_OUT_POL = 1'b1,
  parameter bit INPUT_ONLY  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic         wr_dir,
  input  logic [N-1:0] wval,
  output logic [N-1:0] latch,
  output logic [N-1:0] dir,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  localparam logic [N-1:0] DIR_RST = DIR_OUT_POL ? '0 : '1;

  logic en_data, en_set, en_clr, en_dir;

  assign en_data = wr_data && !SET_CLR && !INPUT_ONLY;
  assign en_set  = wr_set  &&  SET_CLR && !INPUT_ONLY;
  assign en_clr  = wr_clr  &&  SET_CLR && !INPUT_ONLY;
  assign en_dir  = wr_dir  && !INPUT_ONLY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '0;
    end else if (en_data) begin
      latch <= wval;
    end else if (en_set) begin
      latch <= latch | wval;
    end else if (en_clr) begin
      latch <= latch & ~wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dir <= DIR_RST;
    else if (en_dir) dir <= wval;
  end

  if (INPUT_ONLY) begin : g_in_only
    assign pin_out = '0;
    assign pin_oe  = '0;
  end else begin : g_io
    assign pin_out = latch;
    assign pin_oe  = DIR_OUT_POL ? dir : ~dir;
  end

  // R3
  set_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_CLR && !INPUT_ONLY && wr_set) |=> ((latch & $past(wval)) == $past(wval)));

  // R3
  clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_CLR && !INPUT_ONLY && wr_clr) |=> ((latch & $past(wval)) == '0));

  // R7
  input_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (INPUT_ONLY && (wr_data || wr_set || wr_clr || wr_dir)) |=> ($stable(latch) && $stable(dir)));
endmodule

// File: rtl/gpio_rdsel.sv
// Read selection in pin order, registered into a full register word.
module gpio_rdsel
  import gpio_pkg::*;
#(
  parameter int N              = 32,
  parameter int W              = 32,
  parameter bit SET_CLR        = 1'b0,
  parameter bit SET_UNREADABLE = 1'b0,
  parameter bit OUT_READBACK   = 1'b0,
  parameter bit DIR_UNREADABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      latch,
  input  logic [N-1:0]      dir,
  input  logic [N-1:0]      pins,
  output logic [W-1:0]      rd_q
);
  logic [N-1:0] sel;
  logic [W-1:0] ext;

  always_comb begin
    sel = '0;
    case (addr)
      ADR_DATA: sel = OUT_READBACK ? latch : pins;
      ADR_SET:  if (SET_CLR && !SET_UNREADABLE) sel = latch;
      ADR_DIR:  if (!DIR_UNREADABLE) sel = dir;
      default:  sel = '0;
    endcase
  end

  always_comb begin
    ext = '0;
    ext[N-1:0] = sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rd_q <= '0;
    else if (rd) rd_q <= ext;
  end

  // R8
  set_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SET_UNREADABLE && rd && addr == ADR_SET) |=> (rd_q == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int REG_W          = 32,
  parameter int PIN_N          = REG_W,
  parameter bit SET_CLR        = 1'b0,
  parameter bit DIR_OUT_POL    = 1'b1,
  parameter bit MSB_FIRST      = 1'b0,
  parameter bit BIG_ENDIAN     = 1'b0,
  parameter bit INPUT_ONLY     = 1'b0,
  parameter bit SET_UNREADABLE = 1'b0,
  parameter bit OUT_READBACK   = 1'b0,
  parameter bit DIR_UNREADABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [PIN_N-1:0] pin_in,
  output logic [PIN_N-1:0] pin_out,
  output logic [PIN_N-1:0] pin_oe
);
  logic [REG_W-1:0] wmap;
  logic [REG_W-1:0] rd_q;
  logic [PIN_N-1:0] latch, dir, pins_s;
  logic             wr_data, wr_set, wr_clr, wr_dir;
  logic             unused_hi;

  // Incoming bus word into pin order.
  gpio_lane_map #(.W(REG_W), .MSB_FIRST(MSB_FIRST), .BIG_ENDIAN(BIG_ENDIAN)) u_wmap (
    .in_w (reg_wdata),
    .out_w(wmap)
  );
  assign unused_hi = ^wmap;

  assign wr_data = reg_wr && (reg_addr == ADR_DATA);
  assign wr_set  = reg_wr && (reg_addr == ADR_SET);
  assign wr_clr  = reg_wr && (reg_addr == ADR_CLR);
  assign wr_dir  = reg_wr && (reg_addr == ADR_DIR);

  gpio_regs #(
    .N(PIN_N), .SET_CLR(SET_CLR), .DIR_OUT_POL(DIR_OUT_POL), .INPUT_ONLY(INPUT_ONLY)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_data(wr_data),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wr_dir (wr_dir),
    .wval   (wmap[PIN_N-1:0]),
    .latch  (latch),
    .dir    (dir),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );

  gpio_sync #(.N(PIN_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pins_s)
  );

  gpio_rdsel #(
    .N(PIN_N), .W(REG_W), .SET_CLR(SET_CLR), .SET_UNREADABLE(SET_UNREADABLE),
    .OUT_READBACK(OUT_READBACK), .DIR_UNREADABLE(DIR_UNREADABLE)
  ) u_rdsel (
    .clk  (clk),
    .rst_n(rst_n),
    .rd   (reg_rd),
    .addr (reg_addr),
    .latch(latch),
    .dir  (dir),
    .pins (pins_s),
    .rd_q (rd_q)
  );

  // Registered pin-order word back into bus order.
  gpio_lane_map #(.W(REG_W), .MSB_FIRST(MSB_FIRST), .BIG_ENDIAN(BIG_ENDIAN)) u_rmap (
    .in_w (rd_q),
    .out_w(reg_rdata)
  );

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !addr_mapped(reg_addr, SET_CLR)) |=> (reg_rdata == '0));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !addr_mapped(reg_addr, SET_CLR)) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R10
  dir_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DIR_UNREADABLE && reg_rd && reg_addr == ADR_DIR) |=> (reg_rdata == '0));

  // R4
  dir_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!INPUT_ONLY && wr_dir) |=> (pin_oe == (DIR_OUT_POL ? $past(wmap[PIN_N-1:0]) : ~$past(wmap[PIN_N-1:0]))));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DATA = 3'd0, A_SET = 3'd1, A_CLR = 3'd2, A_DIR = 3'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // u0: 16-bit, 12 pins, set/clear, output polarity
  logic [2:0]  a0 = '0;  logic w0 = 0, r0 = 0;
  logic [15:0] wd0 = '0, rdq0;
  logic [11:0] pi0 = '0, po0, oe0;
  // u1: 32-bit single-data, input polarity, MSB-first, byte swap, readback, hidden dir
  logic [2:0]  a1 = '0;  logic w1 = 0, r1 = 0;
  logic [31:0] wd1 = '0, rdq1, pi1 = '0, po1, oe1;
  // u2: 8-bit input-only, set/clear, set unreadable
  logic [2:0]  a2 = '0;  logic w2 = 0, r2 = 0;
  logic [7:0]  wd2 = '0, rdq2, pi2 = '0, po2, oe2;

  gpio_port #(.REG_W(16), .PIN_N(12), .SET_CLR(1'b1), .DIR_OUT_POL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(a0), .reg_wr(w0), .reg_wdata(wd0),
    .reg_rd(r0), .reg_rdata(rdq0), .pin_in(pi0), .pin_out(po0), .pin_oe(oe0));

  gpio_port #(.REG_W(32), .PIN_N(32), .SET_CLR(1'b0), .DIR_OUT_POL(1'b0),
    .MSB_FIRST(1'b1), .BIG_ENDIAN(1'b1), .OUT_READBACK(1'b1), .DIR_UNREADABLE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_addr(a1), .reg_wr(w1), .reg_wdata(wd1),
    .reg_rd(r1), .reg_rdata(rdq1), .pin_in(pi1), .pin_out(po1), .pin_oe(oe1));

  gpio_port #(.REG_W(8), .PIN_N(8), .SET_CLR(1'b1), .INPUT_ONLY(1'b1),
    .SET_UNREADABLE(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .reg_addr(a2), .reg_wr(w2), .reg_wdata(wd2),
    .reg_rd(r2), .reg_rdata(rdq2), .pin_in(pi2), .pin_out(po2), .pin_oe(oe2));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Scoreboard of expected read results.
  int          q_inst[$];
  logic [63:0] q_exp[$];
  string       q_tag[$];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Pin-order vector to bus word: pin i lands on bus bit p.
  function automatic logic [63:0] tomap(input logic [63:0] v, input int w,
                                        input bit msb, input bit be);
    logic [63:0] o;
    o = '0;
    for (int i = 0; i < w; i++) begin
      int r, p;
      r = msb ? (w - 1 - i) : i;
      p = be ? (8 * (w / 8 - 1 - r / 8) + r % 8) : r;
      o[p] = v[i];
    end
    return o;
  endfunction

  task automatic wr(input int inst, input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    case (inst)
      0: begin a0 = a; wd0 = d[15:0]; w0 = 1; end
      1: begin a1 = a; wd1 = d[31:0]; w1 = 1; end
      default: begin a2 = a; wd2 = d[7:0]; w2 = 1; end
    endcase
    @(negedge clk);
    w0 = 0; w1 = 0; w2 = 0;
  endtask

  task automatic rd(input int inst, input logic [2:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    case (inst)
      0: begin a0 = a; r0 = 1; end
      1: begin a1 = a; r1 = 1; end
      default: begin a2 = a; r2 = 1; end
    endcase
    q_inst.push_back(inst); q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    r0 = 0; r1 = 0; r2 = 0;
  endtask

  // Monitor: a read taken at a rising edge is compared at the following falling edge.
  initial begin
    forever begin
      int sel;
      @(posedge clk);
      sel = r0 ? 0 : (r1 ? 1 : (r2 ? 2 : -1));
      if (sel >= 0) begin
        @(negedge clk);
        if (q_inst.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard read with no expected item got %h expected none", 64'h0);
        end else begin
          logic [63:0] got;
          string t;
          logic [63:0] e;
          void'(q_inst.pop_front());
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          got = (sel == 0) ? {48'h0, rdq0} : (sel == 1) ? {32'h0, rdq1} : {56'h0, rdq2};
          chk(t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 u0 pin_oe", {52'h0, oe0}, 64'h0);
    chk("R1 u0 pin_out", {52'h0, po0}, 64'h0);
    chk("R1 u1 pin_oe", {32'h0, oe1}, 64'h0);
    chk("R1 u0 rdata", {48'h0, rdq0}, 64'h0);

    // ---- u0: set/clear, output polarity, 12 of 16 bits ----
    wr(0, A_DIR, 64'h0FF0);
    chk("R4 u0 out polarity", {52'h0, oe0}, 64'h0FF0);
    wr(0, A_SET, 64'h00A5);
    chk("R3 u0 set", {52'h0, po0}, 64'h00A5);
    wr(0, A_SET, 64'h0100);
    chk("R3 u0 set keeps zeros", {52'h0, po0}, 64'h01A5);
    wr(0, A_CLR, 64'h0005);
    chk("R3 u0 clear", {52'h0, po0}, 64'h01A0);
    wr(0, A_DATA, 64'h0FFF);
    chk("R3 u0 data write ignored", {52'h0, po0}, 64'h01A0);
    rd(0, A_SET, 64'h01A0, "R3 u0 set readback");
    rd(0, A_CLR, 64'h0, "R3 u0 clear reads zero");
    rd(0, A_DIR, 64'h0FF0, "R4 u0 dir readback");
    wr(0, A_SET, 64'hF000);
    chk("R12 u0 upper bits no pin", {52'h0, po0}, 64'h01A0);
    rd(0, A_SET, 64'h01A0, "R12 u0 upper bits read zero");
    rd(0, 3'd5, 64'h0, "R11 u0 unmapped read");
    wr(0, 3'd6, 64'hFFFF);
    chk("R11 u0 unmapped write out", {52'h0, po0}, 64'h01A0);
    chk("R11 u0 unmapped write oe", {52'h0, oe0}, 64'h0FF0);
    pi0 = 12'hABC;
    rd(0, A_DATA, 64'h0, "R2 u0 sync latency old");
    rd(0, A_DATA, 64'h0ABC, "R2 u0 sync pins new");

    // ---- u1: single-data, input polarity, MSB-first, byte swap ----
    wr(1, A_DIR, tomap(64'hFFFF_FF00, 32, 1, 1));
    chk("R4 u1 input polarity", {32'h0, oe1}, 64'h0000_00FF);
    rd(1, A_DIR, 64'h0, "R10 u1 dir unreadable");
    pi1 = 32'hDEAD_BEEF;
    wr(1, A_DATA, tomap(64'h1234_5678, 32, 1, 1));
    chk("R2 u1 data drives pins", {32'h0, po1}, 64'h1234_5678);
    rd(1, A_DATA, tomap(64'h1234_5678, 32, 1, 1), "R9 u1 latch readback");
    wr(1, A_DATA, 64'h0000_0080);
    chk("R5 u1 bus bit7 is pin0", {32'h0, po1}, 64'h0000_0001);
    wr(1, A_DATA, 64'h8000_0000);
    chk("R6 u1 bus bit31 is pin24", {32'h0, po1}, 64'h0100_0000);
    rd(1, A_SET, 64'h0, "R11 u1 set unmapped in single mode");
    wr(1, A_SET, 64'hFFFF_FFFF);
    chk("R11 u1 set write ignored", {32'h0, po1}, 64'h0100_0000);

    // ---- u2: input-only ----
    wr(2, A_DIR, 64'hFF);
    wr(2, A_SET, 64'hFF);
    chk("R7 u2 oe stays zero", {56'h0, oe2}, 64'h0);
    chk("R7 u2 out stays zero", {56'h0, po2}, 64'h0);
    rd(2, A_SET, 64'h0, "R8 u2 set unreadable");
    rd(2, A_DIR, 64'h0, "R7 u2 dir write ignored");
    pi2 = 8'h5A;
    repeat (3) @(negedge clk);
    rd(2, A_DATA, 64'h5A, "R2 u2 pins visible");

    repeat (3) @(negedge clk);
    if (q_inst.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard pending got %0d expected %0d", q_inst.size(), 0);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule